// File: doc/BRIEF.md
# I2C Target Address-Match Controller

This block is the target (slave) end of a two-wire serial bus. It watches the clock and data pins through a short synchronizer and detects START and STOP on the synchronized values. While the bus is busy it shifts in a 7-bit address and a direction bit and compares the address with an own address held in a host register. On a match it acknowledges and raises one interrupt line. It then stretches the clock, holding SCL low until the host services the data register. After that it exchanges data bytes in the direction the master asked for.

The pins are open drain. The block outputs "pull low" requests for SCL and SDA, and the pad logic turns these into the wired-AND bus. The host side is a small four-word register window with strobed reads and writes. It holds the own address, the data byte, a status word and a clock-low time-out limit. One interrupt merges three causes: address match, byte complete and time-out. The host tells them apart from the status flags.

Top module: `i2c_tgt_addr_ctrl`

## Requirements
- R1: A falling SDA while SCL is high (START) sets status bit 0 (bus busy). A rising SDA while SCL is high (STOP) clears it and returns the controller to idle.
- R2: The first 7 bits after START are taken MSB first and compared with the own-address register (word 0, bits 6:0). On equality the controller pulls SDA low through the 9th clock as an acknowledge.
- R3: On a match, the 8th bit after START is stored in status bit 2. A value of 1 means the master reads, so the controller transmits. A value of 0 means the master writes, so the controller receives.
- R4: At the falling SCL edge that ends the address acknowledge, the controller sets status bit 1 (addressed) and status bit 4 (interrupt pending, mirrored on `irq_o`). From then on it holds SCL low, shown in status bit 5.
- R5: On an address mismatch, SDA stays released, no interrupt is raised, and later bytes are ignored until the next START. A repeated START carrying the own address is then acknowledged.
- R6: In receive mode, only a read of the data register (word 1) releases a held SCL; a data-register write leaves it held. Each received byte is acknowledged and stored in the data register. At the end of its acknowledge, the byte raises the interrupt with status bit 1 cleared and holds SCL again.
- R7: In transmit mode, only a write of the data register releases a held SCL; a read leaves it held. The written byte is then sent MSB first.
- R8: After a transmitted byte, an acknowledge (SDA low at the 9th clock) from the master raises the byte-complete interrupt and holds SCL. A not-acknowledge releases both lines, raises nothing and ignores the bus until the next START or STOP.
- R9: While the bus is busy, SCL held low for limit x 16 controller clocks raises the time-out. The limit is word 3, and a limit of 0 disables the count. The time-out sets status bit 3 and the interrupt, releases both lines, clears busy and addressed, and returns the controller to idle. The count restarts at every SCL edge.
- R10: Writing the status word (word 2) with bit 4 set clears the interrupt. Writing it with bit 3 set clears the time-out flag.
- R11: The controller changes its SDA drive only while synchronized SCL is low.
- R12: After reset both pull-low outputs are 0, the status word is 0 and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL pin level |
| sda_i | input | 1 | SDA pin level |
| scl_low_o | output | 1 | Request to pull SCL low (clock stretch) |
| sda_low_o | output | 1 | Request to pull SDA low (acknowledge or data 0) |
| reg_wr_i | input | 1 | Host write strobe, one cycle |
| reg_rd_i | input | 1 | Host read strobe, one cycle |
| reg_addr_i | input | 2 | Host word select: 0 own address, 1 data, 2 status, 3 time-out limit |
| reg_wdata_i | input | 8 | Host write data |
| reg_rdata_o | output | 8 | Host read data for the selected word, combinational |
| irq_o | output | 1 | Merged interrupt, high while pending |

## Verification
A pin change reaches the controller after two synchronizer flops and one edge-compare register. Its effect on `sda_low_o`, `scl_low_o` or a status bit therefore appears about three clocks later. A host data-register access lifts SCL stretching on the next clock, and the status word reads back combinationally. The bench master holds each SCL half-period for ten clocks and samples the data line in the middle of the high phase. It reads status only after a full half-period has passed since the last SCL edge, so every response has settled well inside its window. The time-out is checked as a bracket: the flag must still be clear well before limit x 16 clocks of SCL low and must be set well after.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_HOLD,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_SKIP
    } eng_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic scl;
        logic sda;
    } bus_ev_t;

    localparam logic [1:0] RA_OWN  = 2'd0;
    localparam logic [1:0] RA_DATA = 2'd1;
    localparam logic [1:0] RA_STAT = 2'd2;
    localparam logic [1:0] RA_TOUT = 2'd3;

    localparam int SB_BUSY = 0;
    localparam int SB_ADDR = 1;
    localparam int SB_RW   = 2;
    localparam int SB_TOUT = 3;
    localparam int SB_IRQ  = 4;
    localparam int SB_HOLD = 5;

endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync
    import i2c_tgt_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev_o
);
    typedef struct packed {
        logic [STAGES-1:0] scl_sh;
        logic [STAGES-1:0] sda_sh;
        logic              scl_p;
        logic              sda_p;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d        = q;
        d.scl_sh = {q.scl_sh[STAGES-2:0], scl_i};
        d.sda_sh = {q.sda_sh[STAGES-2:0], sda_i};
        d.scl_p  = q.scl_sh[STAGES-1];
        d.sda_p  = q.sda_sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    logic scl_s, sda_s;
    assign scl_s = q.scl_sh[STAGES-1];
    assign sda_s = q.sda_sh[STAGES-1];

    always_comb begin
        ev_o.scl      = scl_s;
        ev_o.sda      = sda_s;
        ev_o.scl_rise = scl_s & ~q.scl_p;
        ev_o.scl_fall = ~scl_s & q.scl_p;
        ev_o.start    = scl_s & q.scl_p & q.sda_p & ~sda_s;
        ev_o.stop     = scl_s & q.scl_p & ~q.sda_p & sda_s;
    end

endmodule

// File: rtl/i2c_bus_timeout.sv
module i2c_bus_timeout #(
    parameter int LIM_W     = 8,
    parameter int PRE_SHIFT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             scl_fall_i,
    input  logic             busy_i,
    input  logic [LIM_W-1:0] limit_i,
    output logic             expire_o
);
    localparam int CNT_W = LIM_W + PRE_SHIFT;

    logic [CNT_W-1:0] cnt_d, cnt_q, lim_full;
    logic             run;

    assign lim_full = CNT_W'(limit_i) << PRE_SHIFT;
    assign run      = busy_i & ~scl_i & (limit_i != '0);

    always_comb begin
        cnt_d = cnt_q;
        if (!run || scl_fall_i)      cnt_d = '0;
        else if (cnt_q != lim_full)  cnt_d = cnt_q + CNT_W'(1);
    end

    assign expire_o = run & ~scl_fall_i & (cnt_q == lim_full - CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_expire_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> !expire_o);

endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  bus_ev_t    ev_i,
    input  logic       expire_i,
    input  logic [6:0] own_addr_i,
    input  logic       rx_release_i,
    input  logic       tx_release_i,
    input  logic [7:0] tx_byte_i,
    output logic       sda_low_o,
    output logic       scl_low_o,
    output logic       busy_o,
    output logic       rw_o,
    output logic [7:0] rx_byte_o,
    output logic       ev_addr_o,
    output logic       ev_byte_o,
    output logic       ev_rx_o,
    output logic       ev_clear_o
);
    localparam int BITS  = 8;
    localparam int CNT_W = $clog2(BITS + 1);

    typedef struct packed {
        eng_state_e       state;
        logic [7:0]       shift;
        logic [CNT_W-1:0] cnt;
        logic             sda_low;
        logic             scl_low;
        logic             busy;
        logic             tx;
        logic             mack;
    } eng_t;

    eng_t q, d;

    always_comb begin
        d          = q;
        ev_addr_o  = 1'b0;
        ev_byte_o  = 1'b0;
        ev_rx_o    = 1'b0;
        ev_clear_o = 1'b0;
        case (q.state)
            ST_ADDR: begin
                if (ev_i.scl_rise) begin
                    d.shift = {q.shift[6:0], ev_i.sda};
                    d.cnt   = q.cnt + CNT_W'(1);
                end else if (ev_i.scl_fall && q.cnt == CNT_W'(BITS)) begin
                    if (q.shift[7:1] == own_addr_i) begin
                        d.sda_low = 1'b1;
                        d.tx      = q.shift[0];
                        d.state   = ST_ADDR_ACK;
                    end else begin
                        d.state   = ST_SKIP;
                    end
                end
            end
            ST_ADDR_ACK: begin
                if (ev_i.scl_fall) begin
                    d.sda_low = 1'b0;
                    d.scl_low = 1'b1;
                    d.state   = ST_HOLD;
                    ev_addr_o = 1'b1;
                end
            end
            ST_HOLD: begin
                if (q.tx && tx_release_i) begin
                    d.shift   = tx_byte_i;
                    d.sda_low = ~tx_byte_i[7];
                    d.cnt     = '0;
                    d.state   = ST_TX;
                end else if (!q.tx && rx_release_i) begin
                    d.scl_low = 1'b0;
                    d.cnt     = '0;
                    d.state   = ST_RX;
                end
            end
            ST_RX: begin
                if (ev_i.scl_rise) begin
                    d.shift = {q.shift[6:0], ev_i.sda};
                    d.cnt   = q.cnt + CNT_W'(1);
                end else if (ev_i.scl_fall && q.cnt == CNT_W'(BITS)) begin
                    d.sda_low = 1'b1;
                    d.state   = ST_RX_ACK;
                end
            end
            ST_RX_ACK: begin
                if (ev_i.scl_fall) begin
                    d.sda_low = 1'b0;
                    d.scl_low = 1'b1;
                    d.state   = ST_HOLD;
                    ev_byte_o = 1'b1;
                    ev_rx_o   = 1'b1;
                end
            end
            ST_TX: begin
                if (q.scl_low) begin
                    d.scl_low = 1'b0;
                end else if (ev_i.scl_fall) begin
                    if (q.cnt == CNT_W'(BITS - 1)) begin
                        d.sda_low = 1'b0;
                        d.state   = ST_TX_ACK;
                    end else begin
                        d.shift   = {q.shift[6:0], 1'b0};
                        d.sda_low = ~q.shift[6];
                        d.cnt     = q.cnt + CNT_W'(1);
                    end
                end
            end
            ST_TX_ACK: begin
                if (ev_i.scl_rise) begin
                    d.mack = ev_i.sda;
                end else if (ev_i.scl_fall) begin
                    if (!q.mack) begin
                        d.scl_low = 1'b1;
                        d.state   = ST_HOLD;
                        ev_byte_o = 1'b1;
                    end else begin
                        d.state   = ST_SKIP;
                    end
                end
            end
            default: ;
        endcase

        if (expire_i || ev_i.stop || ev_i.start) begin
            ev_addr_o  = 1'b0;
            ev_byte_o  = 1'b0;
            ev_rx_o    = 1'b0;
            ev_clear_o = 1'b1;
            d.sda_low  = 1'b0;
            d.scl_low  = 1'b0;
            d.cnt      = '0;
            d.mack     = 1'b1;
            if (expire_i || ev_i.stop) begin
                d.state = ST_IDLE;
                d.busy  = 1'b0;
            end else begin
                d.state = ST_ADDR;
                d.busy  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
            q.mack  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sda_low_o = q.sda_low;
    assign scl_low_o = q.scl_low;
    assign busy_o    = q.busy;
    assign rw_o      = q.tx;
    assign rx_byte_o = q.shift;

    assert_busy_after_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i.start && !expire_i && !ev_i.stop) |=> q.busy);

    assert_idle_after_stop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ev_i.stop |=> (!q.busy && q.state == ST_IDLE));

    assert_hold_needs_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.scl_low) |-> $past(ev_addr_o || ev_byte_o));

    assert_skip_is_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_SKIP) |-> (!q.sda_low && !q.scl_low));

    assert_sda_moves_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sda_low != $past(q.sda_low)) |-> !$past(ev_i.scl));

endmodule

// File: rtl/i2c_host_regs.sv
module i2c_host_regs
    import i2c_tgt_pkg::*;
#(
    parameter int LIM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic             rd_i,
    input  logic [1:0]       addr_i,
    input  logic [7:0]       wdata_i,
    output logic [7:0]       rdata_o,
    output logic [6:0]       own_addr_o,
    output logic [LIM_W-1:0] limit_o,
    output logic             rx_release_o,
    output logic             tx_release_o,
    output logic             irq_o,
    input  logic             busy_i,
    input  logic             hold_i,
    input  logic             rw_i,
    input  logic [7:0]       rx_byte_i,
    input  logic             ev_addr_i,
    input  logic             ev_byte_i,
    input  logic             ev_rx_i,
    input  logic             ev_clear_i,
    input  logic             expire_i
);
    typedef struct packed {
        logic [6:0]       own;
        logic [LIM_W-1:0] lim;
        logic [7:0]       data;
        logic             addressed;
        logic             rw;
        logic             tout;
        logic             irq;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        if (wr_i) begin
            case (addr_i)
                RA_OWN:  d.own  = wdata_i[6:0];
                RA_DATA: d.data = wdata_i;
                RA_STAT: begin
                    if (wdata_i[SB_IRQ])  d.irq  = 1'b0;
                    if (wdata_i[SB_TOUT]) d.tout = 1'b0;
                end
                default: d.lim  = LIM_W'(wdata_i);
            endcase
        end
        if (ev_clear_i) d.addressed = 1'b0;
        if (ev_addr_i) begin
            d.addressed = 1'b1;
            d.rw        = rw_i;
            d.irq       = 1'b1;
        end
        if (ev_byte_i) begin
            d.addressed = 1'b0;
            d.irq       = 1'b1;
        end
        if (ev_rx_i) d.data = rx_byte_i;
        if (expire_i) begin
            d.tout      = 1'b1;
            d.irq       = 1'b1;
            d.addressed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (addr_i)
            RA_OWN:  rdata_o = {1'b0, q.own};
            RA_DATA: rdata_o = q.data;
            RA_STAT: rdata_o = {2'b00, hold_i, q.irq, q.tout, q.rw, q.addressed, busy_i};
            default: rdata_o = 8'(q.lim);
        endcase
    end

    assign own_addr_o   = q.own;
    assign limit_o      = q.lim;
    assign rx_release_o = rd_i && addr_i == RA_DATA;
    assign tx_release_o = wr_i && addr_i == RA_DATA;
    assign irq_o        = q.irq;

    assert_timeout_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        expire_i |=> (q.tout && q.irq && !q.addressed));

    assert_irq_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == RA_STAT && wdata_i[SB_IRQ] && !ev_addr_i && !ev_byte_i && !expire_i)
        |=> !q.irq);

    assert_match_raises_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_addr_i |=> (q.irq && q.addressed));

endmodule

// File: rtl/i2c_tgt_addr_ctrl.sv
module i2c_tgt_addr_ctrl
    import i2c_tgt_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int LIM_W       = 8,
    parameter int PRE_SHIFT   = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_low_o,
    output logic       sda_low_o,
    input  logic       reg_wr_i,
    input  logic       reg_rd_i,
    input  logic [1:0] reg_addr_i,
    input  logic [7:0] reg_wdata_i,
    output logic [7:0] reg_rdata_o,
    output logic       irq_o
);
    bus_ev_t          ev;
    logic             expire, busy, rw;
    logic [6:0]       own_addr;
    logic [LIM_W-1:0] limit;
    logic             rx_release, tx_release;
    logic [7:0]       rx_byte;
    logic             ev_addr, ev_byte, ev_rx, ev_clear;

    i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (ev)
    );

    i2c_bus_timeout #(.LIM_W(LIM_W), .PRE_SHIFT(PRE_SHIFT)) u_tout (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (ev.scl),
        .scl_fall_i (ev.scl_fall),
        .busy_i     (busy),
        .limit_i    (limit),
        .expire_o   (expire)
    );

    i2c_tgt_engine u_eng (
        .clk          (clk),
        .rst_n        (rst_n),
        .ev_i         (ev),
        .expire_i     (expire),
        .own_addr_i   (own_addr),
        .rx_release_i (rx_release),
        .tx_release_i (tx_release),
        .tx_byte_i    (reg_wdata_i),
        .sda_low_o    (sda_low_o),
        .scl_low_o    (scl_low_o),
        .busy_o       (busy),
        .rw_o         (rw),
        .rx_byte_o    (rx_byte),
        .ev_addr_o    (ev_addr),
        .ev_byte_o    (ev_byte),
        .ev_rx_o      (ev_rx),
        .ev_clear_o   (ev_clear)
    );

    i2c_host_regs #(.LIM_W(LIM_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_i         (reg_wr_i),
        .rd_i         (reg_rd_i),
        .addr_i       (reg_addr_i),
        .wdata_i      (reg_wdata_i),
        .rdata_o      (reg_rdata_o),
        .own_addr_o   (own_addr),
        .limit_o      (limit),
        .rx_release_o (rx_release),
        .tx_release_o (tx_release),
        .irq_o        (irq_o),
        .busy_i       (busy),
        .hold_i       (scl_low_o),
        .rw_i         (rw),
        .rx_byte_i    (rx_byte),
        .ev_addr_i    (ev_addr),
        .ev_byte_i    (ev_byte),
        .ev_rx_i      (ev_rx),
        .ev_clear_i   (ev_clear),
        .expire_i     (expire)
    );

endmodule

// File: tb/sim_i2c_tgt_addr_ctrl.sv
module sim_i2c_tgt_addr_ctrl;
    localparam int HALF = 10;
    localparam logic [6:0] OWN = 7'h3A;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       scl_m, sda_m;
    logic       scl_line, sda_line;
    logic       scl_low, sda_low;
    logic       reg_wr, reg_rd;
    logic [1:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic       irq;

    int checks = 0;
    int errors = 0;
    int sda_viol = 0;
    bit done = 1'b0;
    logic prev_sda = 1'b0;

    always #5 clk = ~clk;

    assign scl_line = scl_m & ~scl_low;
    assign sda_line = sda_m & ~sda_low;

    i2c_tgt_addr_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .scl_low_o(scl_low), .sda_low_o(sda_low),
        .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq)
    );

    // R11 monitor: SDA drive must not move while the SCL line is high
    always @(negedge clk) begin
        if (rst_n && sda_low !== prev_sda && scl_line === 1'b1) sda_viol++;
        prev_sda <= sda_low;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic host_rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic stat(input string tag, input logic [7:0] exp);
        @(negedge clk);
        reg_addr = 2'd2;
        #1 chk(tag, reg_rdata, exp);
    endtask

    task automatic wait_scl_high();
        int n = 0;
        while (scl_line !== 1'b1 && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic m_start();
        sda_m = 1'b1; scl_m = 1'b1; cyc(HALF);
        sda_m = 1'b0; cyc(HALF);
        scl_m = 1'b0; cyc(HALF);
    endtask

    task automatic m_rstart();
        sda_m = 1'b1; cyc(HALF);
        scl_m = 1'b1; wait_scl_high(); cyc(HALF);
        sda_m = 1'b0; cyc(HALF);
        scl_m = 1'b0; cyc(HALF);
    endtask

    task automatic m_stop();
        sda_m = 1'b0; cyc(HALF);
        scl_m = 1'b1; wait_scl_high(); cyc(HALF);
        sda_m = 1'b1; cyc(HALF);
    endtask

    task automatic m_wbit(input logic b);
        sda_m = b; cyc(HALF);
        scl_m = 1'b1; wait_scl_high(); cyc(HALF);
        scl_m = 1'b0; cyc(HALF);
    endtask

    task automatic m_rbit(output logic b);
        sda_m = 1'b1; cyc(HALF);
        scl_m = 1'b1; wait_scl_high(); cyc(HALF / 2);
        b = sda_line; cyc(HALF / 2);
        scl_m = 1'b0; cyc(HALF);
    endtask

    task automatic m_wbyte(input logic [7:0] v, output logic ack);
        for (int i = 7; i >= 0; i--) m_wbit(v[i]);
        m_rbit(ack);
    endtask

    task automatic m_rbyte(output logic [7:0] v, input logic ack);
        for (int i = 7; i >= 0; i--) m_rbit(v[i]);
        m_wbit(ack);
    endtask

    task automatic t_reset();
        chk("R12 scl pull after reset", scl_low, 0);
        chk("R12 sda pull after reset", sda_low, 0);
        chk("R12 irq after reset", irq, 0);
        stat("R12 status after reset", 8'h00);
    endtask

    task automatic t_write_flow();
        logic ack;
        logic [7:0] v;
        host_wr(2'd0, {1'b0, OWN});
        host_rd(2'd0, v);
        chk("R2 own address readback", v, {1'b0, OWN});
        m_start();
        stat("R1 busy after START", 8'h01);
        m_wbyte({OWN, 1'b0}, ack);
        chk("R2 address acknowledged", ack, 0);
        chk("R4 SCL held after match", scl_low, 1);
        chk("R4 irq after match", irq, 1);
        stat("R3 R4 status after write-address match", 8'h33);
        host_wr(2'd1, 8'h55);
        cyc(4);
        chk("R6 data write leaves receive hold", scl_low, 1);
        host_wr(2'd2, 8'h10);
        chk("R10 irq cleared by status write", irq, 0);
        host_rd(2'd1, v);
        chk("R6 dummy read value", v, 8'h55);
        cyc(4);
        chk("R6 dummy read releases SCL", scl_low, 0);
        m_wbyte(8'hC3, ack);
        chk("R6 data byte acknowledged", ack, 0);
        chk("R6 SCL held after data byte", scl_low, 1);
        stat("R6 status after received byte", 8'h31);
        host_rd(2'd1, v);
        chk("R6 received byte", v, 8'hC3);
        host_wr(2'd2, 8'h10);
        cyc(4);
        chk("R6 read releases SCL after byte", scl_low, 0);
        m_stop();
        stat("R1 busy cleared by STOP", 8'h00);
    endtask

    task automatic t_read_flow();
        logic ack;
        logic [7:0] v;
        m_start();
        m_wbyte({OWN, 1'b1}, ack);
        chk("R2 read address acknowledged", ack, 0);
        stat("R3 direction bit set for master read", 8'h37);
        host_rd(2'd1, v);
        cyc(4);
        chk("R7 data read leaves transmit hold", scl_low, 1);
        host_wr(2'd2, 8'h10);
        host_wr(2'd1, 8'hA5);
        m_rbyte(v, 1'b0);
        chk("R7 first transmitted byte", v, 8'hA5);
        chk("R8 SCL held after master ACK", scl_low, 1);
        stat("R8 byte-complete status", 8'h35);
        host_wr(2'd2, 8'h10);
        host_wr(2'd1, 8'h3C);
        m_rbyte(v, 1'b1);
        chk("R7 second transmitted byte", v, 8'h3C);
        chk("R8 SCL released after NACK", scl_low, 0);
        chk("R8 SDA released after NACK", sda_low, 0);
        chk("R8 no irq after NACK", irq, 0);
        stat("R8 status after NACK", 8'h05);
        m_stop();
        stat("R1 idle after STOP, direction kept", 8'h04);
    endtask

    task automatic t_mismatch();
        logic ack;
        logic [7:0] v;
        m_start();
        m_wbyte({7'h11, 1'b0}, ack);
        chk("R5 mismatch not acknowledged", ack, 1);
        chk("R5 no irq on mismatch", irq, 0);
        chk("R5 no hold on mismatch", scl_low, 0);
        stat("R5 status after mismatch", 8'h05);
        m_wbyte({OWN, 1'b0}, ack);
        chk("R5 later byte ignored", ack, 1);
        chk("R5 still no irq", irq, 0);
        m_rstart();
        m_wbyte({OWN, 1'b0}, ack);
        chk("R5 repeated START match acknowledged", ack, 0);
        stat("R5 status after repeated START match", 8'h33);
        host_wr(2'd2, 8'h10);
        host_rd(2'd1, v);
        cyc(4);
        m_stop();
        stat("R1 idle after STOP", 8'h00);
    endtask

    task automatic t_timeout();
        logic ack;
        logic [7:0] v;
        host_wr(2'd3, 8'd4);
        m_start();
        m_wbyte({OWN, 1'b0}, ack);
        chk("R2 address acknowledged before time-out", ack, 0);
        host_wr(2'd2, 8'h10);
        cyc(30);
        stat("R9 no time-out yet", 8'h23);
        cyc(60);
        stat("R9 time-out status", 8'h18);
        chk("R9 SCL released on time-out", scl_low, 0);
        chk("R9 irq on time-out", irq, 1);
        host_wr(2'd2, 8'h18);
        stat("R10 flags cleared by status write", 8'h00);
        host_wr(2'd3, 8'd0);
        m_stop();
        m_start();
        m_wbyte({OWN, 1'b0}, ack);
        cyc(150);
        stat("R9 zero limit disables time-out", 8'h33);
        host_wr(2'd2, 8'h10);
        host_rd(2'd1, v);
        cyc(4);
        m_stop();
        stat("R1 idle at end", 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual run still active, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        scl_m = 1'b1; sda_m = 1'b1;
        reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = 2'd0; reg_wdata = 8'h00;
        cyc(5);
        rst_n = 1'b1;
        cyc(3);
        t_reset();
        t_write_flow();
        t_read_flow();
        t_mismatch();
        t_timeout();
        chk("R11 SDA drive changed only with SCL low", sda_viol, 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule